// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller

This block controls one port of eight general-purpose pins through a small memory-mapped register bus with 32-bit data. Software writes an output data register and three per-pin mode registers. Together these decide, for each pin, whether the pad driver is on and what it drives. Pad inputs pass through a two-flop synchroniser before software can read them or the interrupt logic can use them.

Each writable register has three addresses: the base address, a set address and a clear address. Writing a 1 at the set address sets that bit. Writing a 1 at the clear address clears that bit. Writing a 0 at either leaves the bit as it was. This lets software change one pin without a read-modify-write.

A comparison register and a mask register feed a level interrupt. The interrupt stays high while any enabled pin differs from its expected level. Software clears it by changing the expected value or the mask.

Top module: `gpio8_port`

## Requirements
- R1: After reset the output, mode, comparison and mask registers all read 0. Every pin is then a pulled-up input: pad_oe = 0x00, pad_pullup = 0xFF, pad_out = 0x00, and irq is low.
- R2: The output register sits at 0x00. A write at 0x00 loads it. A write at 0x04 ORs the data into it. A write at 0x08 clears the bits that are 1 in the data. Reads at 0x00, 0x04 and 0x08 all return the register.
- R3: Mode register k (k = 0, 1, 2) has its base at 0x20 + 0x10*k, a set alias at base+4 and a clear alias at base+8, with the same write and read rules as R2.
- R4: For each pin, the mode code is {mode2, mode1, mode0}.
  - 000 is an input with pull-up: pad_pullup = 1 and the driver is off.
  - 010 is a push-pull output: pad_oe = 1 and pad_out follows the output bit.
  - Any code with mode2 = 0 and mode0 = 1 is open-drain: pad_out = 0, and pad_oe is the inverse of the output bit.
  - Every code with mode2 = 1 is a plain input: no pull-up and the driver is off.
- R5: A read at 0x10 returns the pad inputs after a two-flop synchroniser. A change on pad_in is visible there after the second rising clock edge, and not after the first.
- R6: The comparison register is at 0x50, with set and clear aliases at 0x54 and 0x58. The mask register is at 0x60, with set and clear aliases at 0x64 and 0x68. Both follow the rules of R2.
- R7: irq is high exactly when some pin has its mask bit at 1 and its synchronised input different from its comparison bit. It stays high until the input, the comparison value or the mask removes that difference. A zero mask holds irq low.
- R8: Reads at any other offset return 0, and writes there change nothing. This includes unaligned offsets, 0x14, 0x18 and offsets above 0x68. Writes at 0x10 are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data, pins in bits 7:0 |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad driver enables |
| pad_pullup | output | 8 | Weak pull-up requests |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a write is a single-cycle pulse of bus_en with bus_wr high, and that bus_addr and bus_wdata hold steady across the clock edge that takes the write. The bench meets this by driving every bus field on the falling edge and lowering bus_en one cycle later. It also changes pad_in only on falling edges, so the two-stage latency to the pin register and to irq can be counted exactly.

// File: rtl/gpio8_port.sv
module gpio8_port #(
  parameter int NPINS = 8,
  parameter int DW    = 32,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pullup,
  output logic             irq
);
  localparam int NMODE = 3;
  localparam logic [3:0] G_OUT = 4'h0, G_PIN = 4'h1, G_MODE0 = 4'h2,
                         G_CMP = 4'h5, G_MSK = 4'h6;

  logic [NPINS-1:0] out_q, cmp_q, msk_q, pin_s;
  logic [NPINS-1:0] mode_q [NMODE];
  logic [NPINS-1:0] sync_q [SYNC];

  wire [3:0] grp = bus_addr[7:4];
  wire [3:0] sub = bus_addr[3:0];
  wire alias_ok = (sub == 4'h0) || (sub == 4'h4) || (sub == 4'h8);
  wire wr = bus_en && bus_wr && alias_ok;
  wire [NPINS-1:0] wd = bus_wdata[NPINS-1:0];
  wire unused_wdata = ^bus_wdata[DW-1:NPINS];

  function automatic logic [NPINS-1:0] upd(input logic [NPINS-1:0] cur,
                                           input logic [3:0] s,
                                           input logic [NPINS-1:0] d);
    case (s)
      4'h4:    return cur | d;
      4'h8:    return cur & ~d;
      default: return d;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      cmp_q <= '0;
      msk_q <= '0;
    end else if (wr) begin
      if (grp == G_OUT) out_q <= upd(out_q, sub, wd);
      if (grp == G_CMP) cmp_q <= upd(cmp_q, sub, wd);
      if (grp == G_MSK) msk_q <= upd(msk_q, sub, wd);
    end
  end

  for (genvar k = 0; k < NMODE; k++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[k] <= '0;
      else if (wr && grp == G_MODE0 + 4'(k)) mode_q[k] <= upd(mode_q[k], sub, wd);
    end
  end

  for (genvar s = 0; s < SYNC; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pad_in;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end
  assign pin_s = sync_q[SYNC-1];

  always_comb begin
    logic [NPINS-1:0] v;
    v = '0;
    if (alias_ok) begin
      case (grp)
        G_OUT: v = out_q;
        G_PIN: v = (sub == 4'h0) ? pin_s : '0;
        G_CMP: v = cmp_q;
        G_MSK: v = msk_q;
        default: v = '0;
      endcase
      for (int k = 0; k < NMODE; k++)
        if (grp == G_MODE0 + 4'(k)) v = mode_q[k];
    end
    bus_rdata = {{(DW-NPINS){1'b0}}, v};
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      logic [2:0] m;
      m = {mode_q[2][i], mode_q[1][i], mode_q[0][i]};
      pad_pullup[i] = (m == 3'b000);
      pad_oe[i]     = 1'b0;
      pad_out[i]    = 1'b0;
      if (!m[2] && m[0]) begin
        pad_oe[i] = ~out_q[i];
      end else if (m == 3'b010) begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = out_q[i];
      end
    end
  end

  assign irq = |((pin_s ^ cmp_q) & msk_q);
endmodule

// File: rtl/gpio8_port_chk.sv
module gpio8_port_chk #(
  parameter int NPINS = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] msk_q,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pullup,
  input logic             irq
);
  p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == 8'h00) |=> out_q == $past(bus_wdata[NPINS-1:0]));

  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == 8'h04) |=> out_q == ($past(out_q) | $past(bus_wdata[NPINS-1:0])));

  p_clr_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == 8'h08) |=> out_q == ($past(out_q) & ~$past(bus_wdata[NPINS-1:0])));

  p_pull_not_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pullup & pad_oe) == '0);

  p_mask_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);

  p_pin_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == 8'h10) |=> $stable(out_q));

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pullup == '1 && !irq));
endmodule

bind gpio8_port gpio8_port_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .out_q(out_q), .msk_q(msk_q),
  .pad_oe(pad_oe), .pad_pullup(pad_pullup), .irq(irq)
);

// File: tb/tb_gpio8_port.sv
module tb_gpio8_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pad_in = '0, pad_out, pad_oe, pad_pullup;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio8_port dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pullup(pad_pullup), .irq(irq));

  // {write addr, write data, read addr, expected read}
  localparam logic [31:0] VEC [16] = '{
    32'h00_A5_00_A5, 32'h04_0A_04_AF, 32'h08_21_08_8E, 32'h04_00_00_8E,
    32'h20_F0_20_F0, 32'h28_30_20_C0, 32'h34_0F_30_0F, 32'h44_81_40_81,
    32'h48_01_48_80, 32'h54_3C_50_3C, 32'h68_FF_60_00, 32'h64_5A_64_5A,
    32'h14_FF_14_00, 32'h7C_FF_00_8E, 32'h02_FF_00_8E, 32'h10_00_00_8E
  };
  localparam string VREQ [16] = '{"R2","R2","R2","R2","R3","R3","R3","R3",
    "R3","R6","R6","R6","R8","R8","R8","R8"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {24'hDEAD00, d};
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    // R1 reset state
    rd(8'h00, v); chk("R1 out", v, 0);
    rd(8'h20, v); chk("R1 mode0", v, 0);
    rd(8'h50, v); chk("R1 cmp", v, 0);
    rd(8'h60, v); chk("R1 msk", v, 0);
    chk("R1 pad_oe", {24'd0, pad_oe}, 0);
    chk("R1 pad_pullup", {24'd0, pad_pullup}, 32'hFF);
    chk("R1 irq", {31'd0, irq}, 0);

    for (int i = 0; i < 16; i++) begin
      wr(VEC[i][31:24], VEC[i][23:16]);
      rd(VEC[i][15:8], v);
      chk(VREQ[i], v, {24'd0, VEC[i][7:0]});
    end

    // R4 mode decode across all eight codes
    do_reset();
    wr(8'h20, 8'hB8); wr(8'h30, 8'hD4); wr(8'h40, 8'hE2); wr(8'h00, 8'h15);
    #1;
    chk("R4 pad_oe", {24'd0, pad_oe}, 32'h0C);
    chk("R4 pad_out", {24'd0, pad_out}, 32'h04);
    chk("R4 pad_pullup", {24'd0, pad_pullup}, 32'h01);
    wr(8'h04, 8'h08);
    #1;
    chk("R4 open-drain release", {24'd0, pad_oe}, 32'h04);
    wr(8'h08, 8'h04);
    #1;
    chk("R4 push-pull low", {24'd0, pad_out}, 32'h00);
    chk("R4 push-pull still driven", {24'd0, pad_oe}, 32'h04);

    // R5 synchroniser latency, R7 interrupt level
    do_reset();
    @(negedge clk); pad_in = 8'h80;
    @(negedge clk); rd(8'h10, v); chk("R5 one edge", v, 0);
    @(negedge clk); rd(8'h10, v); chk("R5 two edges", v, 32'h80);
    wr(8'h64, 8'h80);
    #1 chk("R7 mismatch raises irq", {31'd0, irq}, 1);
    repeat (3) @(negedge clk);
    #1 chk("R7 irq holds", {31'd0, irq}, 1);
    wr(8'h54, 8'h80);
    #1 chk("R7 cmp match clears irq", {31'd0, irq}, 0);
    @(negedge clk); pad_in = 8'h00;
    @(negedge clk); #1 chk("R7 R5 not yet seen", {31'd0, irq}, 0);
    @(negedge clk); #1 chk("R7 input change raises irq", {31'd0, irq}, 1);
    wr(8'h68, 8'h80);
    #1 chk("R7 mask clear drops irq", {31'd0, irq}, 0);
    @(negedge clk); pad_in = 8'h01;
    repeat (3) @(negedge clk);
    #1 chk("R7 unmasked pin ignored", {31'd0, irq}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule